// File: doc/BRIEF.md
# Receive Frame Timing Status Generator

This block sits behind the word-aligned receive path of a radio-link interface. It turns the stream of received 32-bit words into a full position report within the nested frame hierarchy. A basic frame is a fixed number of words. A hyperframe is a fixed number of basic frames. A 10 ms radio frame is a fixed number of hyperframes. Every received word leaves the block one cycle after it enters. It is unchanged and travels together with its own position: word index, basic-frame index, hyperframe number and radio-frame number. Alongside it come start-of-hyperframe and start-of-radio-frame pulses and a synchronisation flag.

The block does not acquire frame synchronisation itself. An upstream state machine raises a lock input. It then marks the first word of a hyperframe with a load strobe that carries the hyperframe and radio-frame numbers of that word. From then on the block counts every valid word. Dropping the lock clears synchronisation in the same output cycle. Synchronisation returns only after the lock is back and a new load strobe arrives.

A start strobe is driven for one complete basic frame. That basic frame is chosen by a programmed offset, given as a (hyperframe, basic frame) pair counted from the radio-frame boundary. Downstream logic can use it to align processing across several link hops.

Top module: `rx_frame_timing`

## Requirements
- R1: `outData` equals the `inData` of the previous cycle, and `outValid` equals the previous cycle's `inValid`.
- R2: `syncState` rises in the output cycle of the first valid word that has `lockIn` and `loadEn` both high. It falls in the output cycle after any cycle with `lockIn` low. It then stays low until a new load word arrives under lock.
- R3: The load word is reported at word index 0 and basic-frame index 0. Its hyperframe number is `loadHf` and its radio-frame number is `loadRf`.
- R4: Each later valid word advances the word index by one. The index wraps from WORDS_PER_BF-1 (3 by default) to 0, and the basic-frame index advances at that wrap. Cycles with `inValid` low leave all indices unchanged.
- R5: The basic-frame index wraps from BF_PER_HF-1 (255) to 0 and advances the hyperframe number. The hyperframe number wraps from HF_PER_RF-1 (149) to 0 and advances the radio-frame number. The radio-frame number is RFN_W bits (12) and wraps from 4095 to 0.
- R6: `hfPulse` is high for exactly one output cycle: the valid word at word index 0 and basic-frame index 0. `rfPulse` is high only on such a word whose hyperframe number is also 0.
- R7: `startStrobe` goes high at word 0 of the basic frame whose (hyperframe, basic frame) equals (`offHf`, `offBf`). It stays high through that frame's idle gaps and remaining words, and falls at word 0 of the next basic frame.
- R8: An `offHf` of HF_PER_RF (150) or more never produces `startStrobe`.
- R9: While `syncState` is low, `hfPulse`, `rfPulse` and `startStrobe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Received word present this cycle |
| inData | input | 32 | Received data or control word |
| lockIn | input | 1 | Upstream frame synchronisation achieved |
| loadEn | input | 1 | Marks the current valid word as the first word of a hyperframe |
| loadHf | input | 8 | Hyperframe number of the load word |
| loadRf | input | 12 | Radio-frame number of the load word |
| offHf | input | 8 | Start offset, hyperframe part |
| offBf | input | 8 | Start offset, basic-frame part |
| outValid | output | 1 | Forwarded word valid |
| outData | output | 32 | Forwarded word |
| syncState | output | 1 | Full frame synchronisation held |
| rfPulse | output | 1 | Start of radio frame |
| hfPulse | output | 1 | Start of hyperframe |
| rfNum | output | 12 | Current radio-frame number |
| hfNum | output | 8 | Current hyperframe number |
| bfIdx | output | 8 | Basic-frame index in hyperframe |
| wordIdx | output | 2 | Word index in basic frame |
| startStrobe | output | 1 | Programmed-offset basic-frame strobe |

## Verification
Every output is registered once, so each result belongs to the input word of the cycle before. This covers forwarded data, indices, pulses, sync flag and start strobe. The bench drives each word on the falling clock edge and reads the outputs just after the following rising edge. There it compares them with the status it expects for that word. The wrap tests push 1024 words through one hyperframe and check the first word of the next one. The start strobe is counted over the whole run, so a strobe at the wrong basic frame or of the wrong length shows up in the count.

// File: rtl/rft_pkg.sv
package rft_pkg;

  // Strobes passed from control to datapath each cycle
  typedef struct packed {
    logic take;    // advance counters with the incoming word
    logic load;    // incoming word is word 0 of basic frame 0
    logic synced;  // full synchronisation for this word
  } ctlStrobe_t;

endpackage

// File: rtl/rft_ctrl.sv
module rft_ctrl
  import rft_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       lockIn,
  input  logic       loadEn,
  output ctlStrobe_t strobe
);

  logic loaded;
  logic loadNow;
  logic syncNow;

  assign loadNow = loadEn & inValid & lockIn;
  assign syncNow = lockIn & (loaded | loadNow);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) loaded <= 1'b0;
    else       loaded <= syncNow;
  end

  always_comb begin
    strobe.take   = inValid & syncNow;
    strobe.load   = loadNow;
    strobe.synced = syncNow;
  end

endmodule

// File: rtl/rft_datapath.sv
module rft_datapath
  import rft_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int WORDS_PER_BF = 4,
  parameter int BF_PER_HF    = 256,
  parameter int HF_PER_RF    = 150,
  parameter int RFN_W        = 12,
  localparam int WW = (WORDS_PER_BF > 1) ? $clog2(WORDS_PER_BF) : 1,
  localparam int BW = $clog2(BF_PER_HF),
  localparam int HW = $clog2(HF_PER_RF)
)(
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inData,
  input  logic [HW-1:0]     loadHf,
  input  logic [RFN_W-1:0]  loadRf,
  input  logic [HW-1:0]     offHf,
  input  logic [BW-1:0]     offBf,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic              syncState,
  output logic              rfPulse,
  output logic              hfPulse,
  output logic [RFN_W-1:0]  rfNum,
  output logic [HW-1:0]     hfNum,
  output logic [BW-1:0]     bfIdx,
  output logic [WW-1:0]     wordIdx,
  output logic              startStrobe
);

  localparam logic [WW-1:0] LAST_W = WW'(WORDS_PER_BF - 1);
  localparam logic [BW-1:0] LAST_B = BW'(BF_PER_HF - 1);
  localparam logic [HW-1:0] LAST_H = HW'(HF_PER_RF - 1);

  // Position expected for the next incoming word
  logic [WW-1:0]    cntW;
  logic [BW-1:0]    cntB;
  logic [HW-1:0]    cntH;
  logic [RFN_W-1:0] cntR;

  // Position of the word in flight this cycle
  logic [WW-1:0]    posW;
  logic [BW-1:0]    posB;
  logic [HW-1:0]    posH;
  logic [RFN_W-1:0] posR;

  logic [WW-1:0]    nxtW;
  logic [BW-1:0]    nxtB;
  logic [HW-1:0]    nxtH;
  logic [RFN_W-1:0] nxtR;
  logic             lastW, lastB, lastH;
  logic             bfStart, hfStart, offHit;

  always_comb begin
    posW = strobe.load ? '0     : cntW;
    posB = strobe.load ? '0     : cntB;
    posH = strobe.load ? loadHf : cntH;
    posR = strobe.load ? loadRf : cntR;

    lastW = (posW == LAST_W);
    lastB = (posB == LAST_B);
    lastH = (posH == LAST_H);

    nxtW = lastW ? '0 : posW + WW'(1);
    nxtB = posB;
    nxtH = posH;
    nxtR = posR;
    if (lastW) begin
      nxtB = lastB ? '0 : posB + BW'(1);
      if (lastB) begin
        nxtH = lastH ? '0 : posH + HW'(1);
        if (lastH) nxtR = posR + RFN_W'(1);
      end
    end

    bfStart = (posW == '0);
    hfStart = bfStart && (posB == '0);
    offHit  = (posH == offHf) && (posB == offBf);
  end

  // Frame position counters
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntW <= '0;
      cntB <= '0;
      cntH <= '0;
      cntR <= '0;
    end else if (strobe.take) begin
      cntW <= nxtW;
      cntB <= nxtB;
      cntH <= nxtH;
      cntR <= nxtR;
    end
  end

  // Output stage: word and its status leave together
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid    <= 1'b0;
      outData     <= '0;
      syncState   <= 1'b0;
      rfPulse     <= 1'b0;
      hfPulse     <= 1'b0;
      rfNum       <= '0;
      hfNum       <= '0;
      bfIdx       <= '0;
      wordIdx     <= '0;
      startStrobe <= 1'b0;
    end else begin
      outValid  <= inValid;
      outData   <= inData;
      syncState <= strobe.synced;
      hfPulse   <= strobe.take && hfStart;
      rfPulse   <= strobe.take && hfStart && (posH == '0);
      if (strobe.take) begin
        wordIdx <= posW;
        bfIdx   <= posB;
        hfNum   <= posH;
        rfNum   <= posR;
      end
      if (!strobe.synced)              startStrobe <= 1'b0;
      else if (strobe.take && bfStart) startStrobe <= offHit;
    end
  end

endmodule

// File: rtl/rx_frame_timing.sv
module rx_frame_timing
  import rft_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int WORDS_PER_BF = 4,
  parameter int BF_PER_HF    = 256,
  parameter int HF_PER_RF    = 150,
  parameter int RFN_W        = 12,
  localparam int WW = (WORDS_PER_BF > 1) ? $clog2(WORDS_PER_BF) : 1,
  localparam int BW = $clog2(BF_PER_HF),
  localparam int HW = $clog2(HF_PER_RF)
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inData,
  input  logic              lockIn,
  input  logic              loadEn,
  input  logic [HW-1:0]     loadHf,
  input  logic [RFN_W-1:0]  loadRf,
  input  logic [HW-1:0]     offHf,
  input  logic [BW-1:0]     offBf,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic              syncState,
  output logic              rfPulse,
  output logic              hfPulse,
  output logic [RFN_W-1:0]  rfNum,
  output logic [HW-1:0]     hfNum,
  output logic [BW-1:0]     bfIdx,
  output logic [WW-1:0]     wordIdx,
  output logic              startStrobe
);

  ctlStrobe_t strobe;

  rft_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .lockIn  (lockIn),
    .loadEn  (loadEn),
    .strobe  (strobe)
  );

  rft_datapath #(
    .DATA_W       (DATA_W),
    .WORDS_PER_BF (WORDS_PER_BF),
    .BF_PER_HF    (BF_PER_HF),
    .HF_PER_RF    (HF_PER_RF),
    .RFN_W        (RFN_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .inValid     (inValid),
    .inData      (inData),
    .loadHf      (loadHf),
    .loadRf      (loadRf),
    .offHf       (offHf),
    .offBf       (offBf),
    .outValid    (outValid),
    .outData     (outData),
    .syncState   (syncState),
    .rfPulse     (rfPulse),
    .hfPulse     (hfPulse),
    .rfNum       (rfNum),
    .hfNum       (hfNum),
    .bfIdx       (bfIdx),
    .wordIdx     (wordIdx),
    .startStrobe (startStrobe)
  );

endmodule

// File: rtl/rx_frame_timing_chk.sv
module rx_frame_timing_chk #(
  parameter int DATA_W       = 32,
  parameter int WORDS_PER_BF = 4,
  parameter int BF_PER_HF    = 256,
  parameter int HF_PER_RF    = 150,
  parameter int RFN_W        = 12,
  localparam int WW = (WORDS_PER_BF > 1) ? $clog2(WORDS_PER_BF) : 1,
  localparam int BW = $clog2(BF_PER_HF),
  localparam int HW = $clog2(HF_PER_RF)
)(
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [DATA_W-1:0] inData,
  input logic              lockIn,
  input logic              loadEn,
  input logic [HW-1:0]     loadHf,
  input logic [RFN_W-1:0]  loadRf,
  input logic              outValid,
  input logic [DATA_W-1:0] outData,
  input logic              syncState,
  input logic              rfPulse,
  input logic              hfPulse,
  input logic [RFN_W-1:0]  rfNum,
  input logic [HW-1:0]     hfNum,
  input logic [BW-1:0]     bfIdx,
  input logic [WW-1:0]     wordIdx,
  input logic              startStrobe
);

  localparam logic [WW-1:0] LAST_W = WW'(WORDS_PER_BF - 1);

  // R1
  data_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (outValid == $past(inValid)) && (outData == $past(inData)));

  // R2
  sync_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    !lockIn |=> !syncState);

  // R3
  load_pos_chk: assert property (@(posedge clk) disable iff (!rstN)
    (loadEn && inValid && lockIn) |=>
      (wordIdx == '0) && (bfIdx == '0) && (hfNum == $past(loadHf)) && (rfNum == $past(loadRf)));

  // R4
  word_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && lockIn && !loadEn && syncState) |=>
      wordIdx == (($past(wordIdx) == LAST_W) ? '0 : $past(wordIdx) + WW'(1)));

  // R6
  rf_within_hf_chk: assert property (@(posedge clk) disable iff (!rstN)
    rfPulse |-> hfPulse && (hfNum == '0));

  // R6
  hf_pulse_pos_chk: assert property (@(posedge clk) disable iff (!rstN)
    hfPulse |-> outValid && (wordIdx == '0) && (bfIdx == '0));

  // R7
  start_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (startStrobe && !inValid && lockIn) |=> startStrobe);

  // R9
  quiet_unsync_chk: assert property (@(posedge clk) disable iff (!rstN)
    !syncState |-> !hfPulse && !rfPulse && !startStrobe);

endmodule

bind rx_frame_timing rx_frame_timing_chk #(
  .DATA_W       (DATA_W),
  .WORDS_PER_BF (WORDS_PER_BF),
  .BF_PER_HF    (BF_PER_HF),
  .HF_PER_RF    (HF_PER_RF),
  .RFN_W        (RFN_W)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .inValid     (inValid),
  .inData      (inData),
  .lockIn      (lockIn),
  .loadEn      (loadEn),
  .loadHf      (loadHf),
  .loadRf      (loadRf),
  .outValid    (outValid),
  .outData     (outData),
  .syncState   (syncState),
  .rfPulse     (rfPulse),
  .hfPulse     (hfPulse),
  .rfNum       (rfNum),
  .hfNum       (hfNum),
  .bfIdx       (bfIdx),
  .wordIdx     (wordIdx),
  .startStrobe (startStrobe)
);

// File: tb/rx_frame_timing_tb.sv
module rx_frame_timing_tb;

  localparam int CLK_NS = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] inData = '0;
  logic        lockIn = 1'b0;
  logic        loadEn = 1'b0;
  logic [7:0]  loadHf = '0;
  logic [11:0] loadRf = '0;
  logic [7:0]  offHf = '0;
  logic [7:0]  offBf = '0;
  logic        outValid, syncState, rfPulse, hfPulse, startStrobe;
  logic [31:0] outData;
  logic [11:0] rfNum;
  logic [7:0]  hfNum, bfIdx;
  logic [1:0]  wordIdx;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  rx_frame_timing u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .lockIn(lockIn), .loadEn(loadEn), .loadHf(loadHf), .loadRf(loadRf),
    .offHf(offHf), .offBf(offBf), .outValid(outValid), .outData(outData),
    .syncState(syncState), .rfPulse(rfPulse), .hfPulse(hfPulse),
    .rfNum(rfNum), .hfNum(hfNum), .bfIdx(bfIdx), .wordIdx(wordIdx),
    .startStrobe(startStrobe)
  );

  typedef struct packed {
    logic       v, l, ld;
    logic       eSync, eHfP, eRfP, eStart;
    logic       chkPos;
    logic [1:0] eWord;
    logic [7:0] eBf;
    logic [7:0] eHf;
    logic [11:0] eRf;
  } vec_t;

  localparam logic T = 1'b1;
  localparam logic F = 1'b0;

  // Load hf=5 rf=100, start offset (5,1)
  localparam vec_t TBL [15] = '{
    '{T,F,F, F,F,F,F, F, 2'd0, 8'd0, 8'd0, 12'd0},
    '{T,T,F, F,F,F,F, F, 2'd0, 8'd0, 8'd0, 12'd0},
    '{T,T,T, T,T,F,F, T, 2'd0, 8'd0, 8'd5, 12'd100},
    '{T,T,F, T,F,F,F, T, 2'd1, 8'd0, 8'd5, 12'd100},
    '{F,T,F, T,F,F,F, T, 2'd1, 8'd0, 8'd5, 12'd100},
    '{T,T,F, T,F,F,F, T, 2'd2, 8'd0, 8'd5, 12'd100},
    '{T,T,F, T,F,F,F, T, 2'd3, 8'd0, 8'd5, 12'd100},
    '{T,T,F, T,F,F,T, T, 2'd0, 8'd1, 8'd5, 12'd100},
    '{F,T,F, T,F,F,T, T, 2'd0, 8'd1, 8'd5, 12'd100},
    '{T,T,F, T,F,F,T, T, 2'd1, 8'd1, 8'd5, 12'd100},
    '{T,T,F, T,F,F,T, T, 2'd2, 8'd1, 8'd5, 12'd100},
    '{T,T,F, T,F,F,T, T, 2'd3, 8'd1, 8'd5, 12'd100},
    '{T,T,F, T,F,F,F, T, 2'd0, 8'd2, 8'd5, 12'd100},
    '{T,F,F, F,F,F,F, F, 2'd0, 8'd0, 8'd0, 12'd0},
    '{T,T,F, F,F,F,F, F, 2'd0, 8'd0, 8'd0, 12'd0}
  };

  task automatic drive(input logic v, input logic l, input logic ld, input logic [31:0] d);
    @(negedge clk);
    inValid = v; lockIn = l; loadEn = ld; inData = d;
    @(posedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Runs n valid words under lock, counting cycles with startStrobe high
  task automatic runWords(input int n, inout int startCnt);
    for (int i = 0; i < n; i++) begin
      drive(1'b1, 1'b1, 1'b0, 32'h5A000000 + i);
      if (startStrobe) startCnt++;
    end
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int sc;
    repeat (3) @(posedge clk);
    #1;
    // Reset state (R2, R9)
    check(!outValid && !syncState && !hfPulse && !rfPulse && !startStrobe &&
          outData == 0 && wordIdx == 0 && bfIdx == 0 && hfNum == 0 && rfNum == 0,
          "R2 R9", "reset state", {27'd0, outValid, syncState, hfPulse, rfPulse, startStrobe}, 32'd0);
    @(negedge clk);
    rstN = 1'b1;
    loadHf = 8'd5; loadRf = 12'd100; offHf = 8'd5; offBf = 8'd1;

    // Vector table: R1 R2 R3 R4 R6 R7 R9
    for (int i = 0; i < 15; i++) begin
      logic [31:0] d;
      logic ok;
      d = 32'hC0DE0000 + i;
      drive(TBL[i].v, TBL[i].l, TBL[i].ld, d);
      ok = (outValid == TBL[i].v) && (!TBL[i].v || outData == d) &&
           (syncState == TBL[i].eSync) && (hfPulse == TBL[i].eHfP) &&
           (rfPulse == TBL[i].eRfP) && (startStrobe == TBL[i].eStart);
      if (TBL[i].chkPos)
        ok = ok && (wordIdx == TBL[i].eWord) && (bfIdx == TBL[i].eBf) &&
             (hfNum == TBL[i].eHf) && (rfNum == TBL[i].eRf);
      check(ok, "R1 R2 R3 R4 R6 R7 R9", $sformatf("row %0d", i),
            {outValid, syncState, hfPulse, rfPulse, startStrobe, wordIdx, bfIdx, hfNum, 9'd0},
            {TBL[i].v, TBL[i].eSync, TBL[i].eHfP, TBL[i].eRfP, TBL[i].eStart,
             TBL[i].eWord, TBL[i].eBf, TBL[i].eHf, 9'd0});
    end

    // Hyperframe rollover within a radio frame, start at last basic frame
    loadHf = 8'd10; loadRf = 12'd7; offHf = 8'd10; offBf = 8'd255;
    sc = 0;
    drive(1'b1, 1'b1, 1'b1, 32'h11112222);
    check(syncState && hfPulse && !rfPulse && hfNum == 10 && rfNum == 7,
          "R3", "reload after loss", {20'd0, rfNum}, 32'd7);
    runWords(1023, sc);
    check(wordIdx == 3 && bfIdx == 255 && hfNum == 10, "R4",
          "last word of hyperframe", {22'd0, wordIdx, bfIdx}, {22'd0, 2'd3, 8'd255});
    // R7: the start strobe covers the four words of basic frame 255
    check(sc == 4, "R7", "start strobe word count", sc, 32'd4);
    runWords(1, sc);
    // R5
    check(wordIdx == 0 && bfIdx == 0 && hfNum == 11 && rfNum == 7, "R5",
          "basic frame wrap into next hyperframe", {12'd0, hfNum, rfNum}, {12'd0, 8'd11, 12'd7});
    // R6
    check(hfPulse && !rfPulse, "R6", "hyperframe pulse only",
          {30'd0, hfPulse, rfPulse}, 32'd2);
    drive(1'b1, 1'b1, 1'b0, 32'h0);
    check(!hfPulse && !startStrobe, "R6", "pulse one cycle",
          {30'd0, hfPulse, startStrobe}, 32'd0);

    // Radio-frame and number wrap, out-of-range offset
    loadHf = 8'd149; loadRf = 12'd4095; offHf = 8'd200; offBf = 8'd0;
    sc = 0;
    drive(1'b1, 1'b1, 1'b1, 32'h33334444);
    if (startStrobe) sc++;
    runWords(1023, sc);
    runWords(1, sc);
    // R5
    check(hfNum == 0 && rfNum == 0 && bfIdx == 0 && wordIdx == 0, "R5",
          "hyperframe and radio-frame wrap", {12'd0, hfNum, rfNum}, 32'd0);
    // R6
    check(rfPulse && hfPulse, "R6", "radio-frame pulse at wrap",
          {30'd0, rfPulse, hfPulse}, 32'd3);
    // R8
    check(sc == 0, "R8", "no start with offset beyond frame", sc, 32'd0);

    // Lock loss: pulses stop, sync falls at once (R2, R9)
    drive(1'b1, 1'b0, 1'b0, 32'h0);
    check(!syncState && !startStrobe && !hfPulse, "R2", "sync falls on lock loss",
          {29'd0, syncState, startStrobe, hfPulse}, 32'd0);
    sc = 0;
    for (int i = 0; i < 8; i++) begin
      drive(1'b1, 1'b1, 1'b0, 32'h0);
      if (syncState || hfPulse || rfPulse || startStrobe) sc++;
    end
    check(sc == 0, "R9", "quiet until reload", sc, 32'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule